// File: doc/BRIEF.md
# Dual-Counter Performance Monitor Unit

This block counts hardware events for a processor core in two 32-bit counters. A register port gives access to three registers: a shared control register, a 64-bit counter word that holds both counters, and an overflow status register. Each counter has its own 6-bit event selector in the control register. One user-context enable bit and one supervisor-context enable bit gate counting, and each bit acts on both counters at once. Neither counter can be stopped alone. To park an idle counter, software selects the special-NOP event, which almost never fires.

The core supplies one pulse per cycle for each event: cycles, retired instructions, cache references, cache misses and special-NOP executions. It also supplies the current privilege level. When a counter wraps from all ones to zero, it sets a sticky status bit. The interrupt output is high while any status bit is set. Because both counters share one word, software updates a single counter by reading the word, replacing one half and writing the whole word back.

Top module: `dual_pmu`

## Requirements
- R1: After reset the control register, both counters and both status bits read zero, so nothing counts and `irq` is low.
- R2: Register addresses are 0 for control, 1 for the counter word, 2 for status, and 3 reads zero. The control register has these fields: upper-counter event select in bits 16:11, lower-counter event select in bits 9:4, user enable in bit 2 and supervisor enable in bit 1. All other bits read zero and ignore writes.
- R3: The counter word holds the upper counter in bits 63:32 and the lower counter in bits 31:0. A write to address 1 loads both halves at once.
- R4: A counter adds one on each clock edge where its selected event pulse is high and the enable bit for the current privilege is set. When `priv_super` is 1 the supervisor enable (bit 1) applies; when it is 0 the user enable (bit 2) applies.
- R5: With both enable bits clear, neither counter changes, whatever the event pulses do.
- R6: Event code 0x00 counts cycles and code 0x01 counts retired instructions, on either counter.
- R7: Event code 0x09 counts cache references on the lower counter and cache misses on the upper counter.
- R8: Code 0x1C on the upper counter and code 0x14 on the lower counter count special-NOP pulses. Any code not listed for a counter (for example 0x14 on the upper counter or 0x1C on the lower) counts nothing.
- R9: A write to the counter word takes priority over an increment in the same cycle. The written value is stored unchanged.
- R10: A counter that steps from 0xFFFFFFFF to 0 sets its sticky status bit: bit 1 for the upper counter, bit 0 for the lower. `irq` is the OR of the two status bits.
- R11: Writing a 1 to a status bit at address 2 clears it, and writing 0 leaves it as it is. If a wrap and a clear of the same bit happen in one cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| priv_super | input | 1 | 1 when the core runs in supervisor context |
| ev_cycle | input | 1 | Cycle event pulse |
| ev_instr | input | 1 | Retired-instruction pulse |
| ev_cache_ref | input | 1 | Cache-reference pulse |
| ev_cache_miss | input | 1 | Cache-miss pulse |
| ev_spec_nop | input | 1 | Special-NOP-executed pulse |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that the event pulses, `priv_super` and the register-port inputs are stable around each rising edge. They also assume that a write lasts exactly one cycle with its address and data valid for that cycle. The bench changes every input only at falling edges and raises `reg_wr` for a single cycle per access. Reads are combinational, so the bench samples them after a falling edge and without a clock. The event pulses are cleared before each read, so the values stay still while they are checked.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int CNT_W     = 32;
    localparam int NUM_CNT   = 2;
    localparam int WORD_W    = CNT_W * NUM_CNT;
    localparam int SEL_W     = 6;
    localparam int HI_SEL_LSB = 11;
    localparam int LO_SEL_LSB = 4;
    localparam int USER_EN_BIT  = 2;
    localparam int SUPER_EN_BIT = 1;
    localparam int IDX_LO = 0;
    localparam int IDX_HI = 1;

    localparam logic [SEL_W-1:0] EV_CYCLES  = 6'h00;
    localparam logic [SEL_W-1:0] EV_INSTR   = 6'h01;
    localparam logic [SEL_W-1:0] EV_CACHE   = 6'h09;
    localparam logic [SEL_W-1:0] EV_NOP_HI  = 6'h1C;
    localparam logic [SEL_W-1:0] EV_NOP_LO  = 6'h14;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_CNT  = 2'd1,
        A_STAT = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic cycle;
        logic instr;
        logic cref;
        logic cmiss;
        logic snop;
    } evt_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel_hi;
        logic [SEL_W-1:0] sel_lo;
        logic             en_user;
        logic             en_super;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[HI_SEL_LSB +: SEL_W] = c.sel_hi;
        w[LO_SEL_LSB +: SEL_W] = c.sel_lo;
        w[USER_EN_BIT]         = c.en_user;
        w[SUPER_EN_BIT]        = c.en_super;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.sel_hi   = w[HI_SEL_LSB +: SEL_W];
        c.sel_lo   = w[LO_SEL_LSB +: SEL_W];
        c.en_user  = w[USER_EN_BIT];
        c.en_super = w[SUPER_EN_BIT];
        return c;
    endfunction

    function automatic logic event_pick(input logic is_hi,
                                        input logic [SEL_W-1:0] sel,
                                        input evt_t e);
        logic hit;
        hit = 1'b0;
        if (sel == EV_CYCLES)                 hit = e.cycle;
        else if (sel == EV_INSTR)             hit = e.instr;
        else if (sel == EV_CACHE)             hit = is_hi ? e.cmiss : e.cref;
        else if (is_hi && sel == EV_NOP_HI)   hit = e.snop;
        else if (!is_hi && sel == EV_NOP_LO)  hit = e.snop;
        return hit;
    endfunction
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst)     ctrl <= '0;
        else if (wr) ctrl <= unpack_ctrl(wdata);
    end

    // R1: control comes out of reset with both enables clear
    a_r1_ctrl_reset: assert property (@(posedge clk)
        $past(rst) |-> (!ctrl.en_user && !ctrl.en_super));
endmodule

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
    import pmu_pkg::*;
#(
    parameter bit IS_HI = 1'b0
) (
    input  logic [SEL_W-1:0] sel,
    input  evt_t             evt,
    output logic             hit
);
    always_comb hit = event_pick(IS_HI, sel, evt);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic wrap;
    always_comb wrap = inc && !load && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (load)     cnt <= load_val;
            else if (inc) cnt <= cnt + 1'b1;
            if (wrap)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    // R10: a wrap leaves the counter at zero with its status bit set
    a_r10_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && cnt == {CNT_W{1'b1}}) |=> (ovf && cnt == '0));
    // R9: a load wins over an increment
    a_r9_write_priority: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
    // R4: without load or increment the count holds
    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!load && !inc) |=> $stable(cnt));
    // R11: status is sticky unless cleared
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/dual_pmu.sv
module dual_pmu
    import pmu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    input  logic        priv_super,
    input  logic        ev_cycle,
    input  logic        ev_instr,
    input  logic        ev_cache_ref,
    input  logic        ev_cache_miss,
    input  logic        ev_spec_nop,
    output logic        irq
);
    ctrl_t                     ctrl_q;
    evt_t                      evt;
    logic                      count_en;
    logic                      ctrl_wr, cnt_load;
    logic [NUM_CNT-1:0]        hit, inc, ovf, ovf_clr;
    logic [WORD_W-1:0]         cnt_word;

    always_comb begin
        evt.cycle = ev_cycle;
        evt.instr = ev_instr;
        evt.cref  = ev_cache_ref;
        evt.cmiss = ev_cache_miss;
        evt.snop  = ev_spec_nop;
        ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
        cnt_load  = reg_wr && (reg_addr == A_CNT);
        count_en  = priv_super ? ctrl_q.en_super : ctrl_q.en_user;
    end

    pmu_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctrl_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl_q)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam bit HI = (i == IDX_HI);
        logic [SEL_W-1:0] sel;
        always_comb begin
            sel        = HI ? ctrl_q.sel_hi : ctrl_q.sel_lo;
            inc[i]     = hit[i] && count_en;
            ovf_clr[i] = reg_wr && (reg_addr == A_STAT) && reg_wdata[i];
        end

        pmu_event_sel #(.IS_HI(HI)) u_sel (
            .sel (sel),
            .evt (evt),
            .hit (hit[i])
        );

        pmu_counter u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (cnt_load),
            .load_val (reg_wdata[i*CNT_W +: CNT_W]),
            .inc      (inc[i]),
            .ovf_clr  (ovf_clr[i]),
            .cnt      (cnt_word[i*CNT_W +: CNT_W]),
            .ovf      (ovf[i])
        );
    end

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            A_CTRL:  reg_rdata = pack_ctrl(ctrl_q);
            A_CNT:   reg_rdata = cnt_word;
            A_STAT:  reg_rdata = {{(WORD_W-NUM_CNT){1'b0}}, ovf};
            default: reg_rdata = '0;
        endcase
        irq = |ovf;
    end

    // R5: both enables off freezes both counters unless software writes
    a_r5_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en_user && !ctrl_q.en_super && !cnt_load) |=> $stable(cnt_word));
    // R10: an interrupt only rises after a counter stepped
    a_r10_irq_from_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|inc));
endmodule

// File: tb/dual_pmu_tb.sv
module dual_pmu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        priv_super;
    logic        ev_cycle, ev_instr, ev_cache_ref, ev_cache_miss, ev_spec_nop;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pmu dut_i (
        .clk (clk), .rst (rst),
        .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .priv_super (priv_super),
        .ev_cycle (ev_cycle), .ev_instr (ev_instr),
        .ev_cache_ref (ev_cache_ref), .ev_cache_miss (ev_cache_miss),
        .ev_spec_nop (ev_spec_nop),
        .irq (irq)
    );

    localparam logic [63:0] CTRL_MASK = 64'h1FBF6;

    function automatic logic [63:0] ctrl_val(input logic [5:0] hi, input logic [5:0] lo,
                                             input logic u, input logic s);
        return (64'(hi) << 11) | (64'(lo) << 4) | (64'(u) << 2) | (64'(s) << 1);
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(input int n, input logic c, input logic i, input logic r,
                       input logic m, input logic s);
        @(negedge clk);
        {ev_cycle, ev_instr, ev_cache_ref, ev_cache_miss, ev_spec_nop} = {c, i, r, m, s};
        repeat (n) @(negedge clk);
        {ev_cycle, ev_instr, ev_cache_ref, ev_cache_miss, ev_spec_nop} = '0;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd(2'd0, d); check("R1 ctrl", d, 64'h0);
        rd(2'd1, d); check("R1 counters", d, 64'h0);
        rd(2'd2, d); check("R1 status", d, 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
    endtask

    task automatic t_ctrl_fields();
        logic [63:0] d;
        wr(2'd0, '1);
        rd(2'd0, d); check("R2 reserved bits read zero", d, CTRL_MASK);
        rd(2'd3, d); check("R2 unused address", d, 64'h0);
        wr(2'd0, 64'h0);
        rd(2'd0, d); check("R2 cleared", d, 64'h0);
    endtask

    task automatic t_cycles_instr();
        logic [63:0] d;
        priv_super = 1'b0;
        wr(2'd0, ctrl_val(6'h00, 6'h01, 1'b1, 1'b0));
        run(3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run(2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd1, d); check("R6 R3 cycles hi / instr lo", d, {32'd5, 32'd3});
        priv_super = 1'b1;
        run(4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        rd(2'd1, d); check("R4 supervisor enable off", d, {32'd5, 32'd3});
        wr(2'd0, ctrl_val(6'h01, 6'h00, 1'b0, 1'b1));
        run(2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd1, d); check("R4 R6 supervisor counts, swapped codes", d, {32'd5, 32'd5});
    endtask

    task automatic t_disabled();
        logic [63:0] d;
        wr(2'd1, 64'h0);
        wr(2'd0, ctrl_val(6'h00, 6'h00, 1'b0, 1'b0));
        priv_super = 1'b0;
        run(6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        priv_super = 1'b1;
        run(6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        rd(2'd1, d); check("R5 both enables clear", d, 64'h0);
    endtask

    task automatic t_cache();
        logic [63:0] d;
        priv_super = 1'b1;
        wr(2'd0, ctrl_val(6'h09, 6'h09, 1'b0, 1'b1));
        run(4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run(2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(2'd1, d); check("R7 misses hi / refs lo", d, {32'd2, 32'd4});
    endtask

    task automatic t_nop();
        logic [63:0] d;
        wr(2'd1, 64'h0);
        wr(2'd0, ctrl_val(6'h1C, 6'h14, 1'b0, 1'b1));
        run(3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run(3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        rd(2'd1, d); check("R8 nop codes count nops only", d, {32'd3, 32'd3});
        wr(2'd0, ctrl_val(6'h14, 6'h1C, 1'b0, 1'b1));
        run(5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        rd(2'd1, d); check("R8 wrong-side nop codes frozen", d, {32'd3, 32'd3});
    endtask

    task automatic t_write_priority();
        logic [63:0] d;
        priv_super = 1'b0;
        wr(2'd0, ctrl_val(6'h00, 6'h00, 1'b1, 1'b0));
        @(negedge clk);
        ev_cycle = 1'b1; reg_addr = 2'd1; reg_wdata = {32'h1234_0000, 32'h0000_0abc}; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_cycle = 1'b0;
        rd(2'd1, d); check("R9 write beats increment", d, {32'h1234_0000, 32'h0000_0abc});
        run(1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd1, d); check("R9 R3 counts on after write", d, {32'h1234_0001, 32'h0000_0abd});
    endtask

    task automatic t_wrap_and_clear();
        logic [63:0] d;
        wr(2'd1, {32'hFFFF_FFFE, 32'hFFFF_FFFF});
        rd(2'd2, d); check("R10 no status before wrap", d, 64'h0);
        run(1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd1, d); check("R10 lower wrapped", d, {32'hFFFF_FFFF, 32'h0});
        rd(2'd2, d); check("R10 lower status", d, 64'h1);
        check("R10 irq on", 64'(irq), 64'h1);
        run(1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd2, d); check("R10 both status", d, 64'h3);
        wr(2'd2, 64'h1);
        rd(2'd2, d); check("R11 clear lower only", d, 64'h2);
        check("R11 irq still on", 64'(irq), 64'h1);
        wr(2'd2, 64'h0);
        rd(2'd2, d); check("R11 write zero keeps", d, 64'h2);
        wr(2'd2, 64'h2);
        rd(2'd2, d); check("R11 clear upper", d, 64'h0);
        check("R11 irq off", 64'(irq), 64'h0);
        wr(2'd1, {32'h0, 32'hFFFF_FFFF});
        @(negedge clk);
        ev_cycle = 1'b1; reg_addr = 2'd2; reg_wdata = 64'h1; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_cycle = 1'b0;
        rd(2'd2, d); check("R11 wrap wins over clear", d, 64'h1);
    endtask

    initial begin
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; priv_super = 1'b0;
        {ev_cycle, ev_instr, ev_cache_ref, ev_cache_miss, ev_spec_nop} = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_fields();
        t_cycles_instr();
        t_disabled();
        t_cache();
        t_nop();
        t_write_priority();
        t_wrap_and_clear();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule